// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of an eight-input interrupt controller. Each input line is captured into a request bit, either by following the line's level or by catching its rising edge, as a per-input trigger-mode bit selects. The requests that the mask leaves visible are ranked under a rotating priority base. The best of them is offered to the processor side only when it outranks everything already in service.

Command decoding, bus access and cascading live elsewhere and drive the control inputs: the mask, the trigger modes, the mode flags, an end-of-service clear vector and an acknowledge strobe. An acknowledge moves the current winner into service. With automatic end-of-service enabled, the acknowledge instead leaves in-service untouched and can rotate the priority base so that the serviced input becomes the lowest priority. The output request and the winning index are combinational from the registered request, in-service and base state and the current control inputs.

Top module: `irq_resolver`

## Requirements
- R1: For an input in level mode (trig_level bit = 1), its request bit equals the line value sampled at the previous clock edge, so the output can rise or fall one cycle after the line does.
- R2: For an input in edge mode (trig_level bit = 0), the request bit is set when the line is high at a clock edge and was low at the edge before. A low line does not clear the request bit; it only resets the stored previous level.
- R3: Input index k sits at priority position (k - base) mod 8, and position 0 ranks highest. The base is 0 after reset. out_idx gives the index of the best pending input.
- R4: An input is pending when its request bit is 1 and its mask bit is 0. With nothing pending, out_req is 0.
- R5: out_req is 1 only when the best pending position is strictly better than the best in-service position. An in-service input of equal or higher rank blocks the output.
- R6: When is_master = 1 and nested_mode = 1, in-service bit 2 is left out of the R5 comparison. With either flag at 0, bit 2 takes part like any other.
- R7: An ack while out_req = 1 sets the in-service bit of out_idx and clears its request bit only if that input is in edge mode. A level-mode request stays set.
- R8: When auto_eoi = 1, an accepted ack sets no in-service bit. If rotate_aeoi = 1 as well, the base becomes (out_idx + 1) mod 8; otherwise the base is unchanged.
- R9: Each 1 bit of isr_clr clears that in-service bit at the clock edge. When an accepted ack sets the same bit in the same cycle, the bit ends up set.
- R10: An ack while out_req = 0 changes no request bit, in-service bit or base.
- R11: When an ack clears an edge-mode request and a new rising edge arrives on that same input in the same cycle, the request bit stays set.
- R12: A synchronous active-high reset clears all request, in-service and previous-level bits and the base, so out_req is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lines | input | 8 | Interrupt request input lines |
| mask | input | 8 | Per-input mask, 1 hides the request |
| trig_level | input | 8 | Per-input trigger mode, 1 = level, 0 = edge |
| is_master | input | 1 | This controller is the first in a cascade |
| nested_mode | input | 1 | Special fully nested mode enable |
| auto_eoi | input | 1 | Automatic end-of-service at acknowledge |
| rotate_aeoi | input | 1 | Rotate the priority base on automatic end-of-service |
| isr_clr | input | 8 | In-service bits to clear at the next edge |
| ack | input | 1 | Acknowledge of the current winner |
| out_req | output | 1 | Interrupt request toward the processor |
| out_idx | output | 3 | Index of the winning pending input |

## Verification
Two pairs of functions can land in the same clock edge. First, an acknowledge clearing an edge-mode request can meet a new rising edge on that same line. The bench raises the line in the acknowledge cycle, after dropping it earlier so that the previous level is low. It then clears in-service and expects that input to win again. Second, an acknowledge can set an in-service bit while the clear vector names that same bit. The bench drives both together with a lower-ranked request pending and expects the output to stay low, because the set must win.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned IRQ_LINES = 8;
  localparam int unsigned CASCADE_POS = 2;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_res_pkg::*;
#(
  parameter int unsigned N = IRQ_LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic req_q, prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= line_i[g];
        if (trig_mode_e'(mode_i[g]) == TRIG_LEVEL) begin
          req_q <= line_i[g];
        end else begin
          // a fresh rising edge outranks the acknowledge clear
          req_q <= (req_q & ~take_i[g]) | (line_i[g] & ~prev_q);
        end
      end
    end

    assign req_o[g]  = req_q;
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic          found_o,
  output logic [IW-1:0] pos_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int p = N - 1; p >= 0; p--) begin
      if (vec_i[IW'(p) + base_i]) begin
        found_o = 1'b1;
        pos_o   = IW'(p);
      end
    end
    idx_o = pos_o + base_i;
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic [IW-1:0] win_i,
  input  logic          auto_i,
  input  logic          rot_i,
  input  logic [N-1:0]  clr_i,
  output logic [N-1:0]  isr_o,
  output logic [IW-1:0] base_o
);
  logic [N-1:0]  isr_q;
  logic [IW-1:0] base_q;
  logic [N-1:0]  set_v;

  assign set_v = (take_i && !auto_i) ? (N'(1) << win_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q <= (isr_q & ~clr_i) | set_v;
      if (take_i && auto_i && rot_i) begin
        base_q <= win_i + 1'b1;
      end
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned N    = IRQ_LINES,
  parameter int unsigned CASC = CASCADE_POS,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_lines,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  trig_level,
  input  logic          is_master,
  input  logic          nested_mode,
  input  logic          auto_eoi,
  input  logic          rotate_aeoi,
  input  logic [N-1:0]  isr_clr,
  input  logic          ack,
  output logic          out_req,
  output logic [IW-1:0] out_idx
);
  logic [N-1:0]  irr_q, prev_q, isr_q, isr_eff, pend, take_v;
  logic [IW-1:0] base_q, pend_pos, isr_pos, isr_idx;
  logic          pend_any, isr_any, ack_ok;

  assign ack_ok = ack & out_req;
  assign take_v = ack_ok ? (N'(1) << out_idx) : '0;

  irq_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .line_i(req_lines), .mode_i(trig_level),
    .take_i(take_v), .req_o(irr_q), .prev_o(prev_q)
  );

  irq_svc_track #(.N(N)) u_svc (
    .clk(clk), .rst(rst), .take_i(ack_ok), .win_i(out_idx),
    .auto_i(auto_eoi), .rot_i(rotate_aeoi), .clr_i(isr_clr),
    .isr_o(isr_q), .base_o(base_q)
  );

  assign pend    = irr_q & ~mask;
  assign isr_eff = (is_master && nested_mode) ? (isr_q & ~(N'(1) << CASC)) : isr_q;

  irq_prio_pick #(.N(N)) u_pick_pend (
    .vec_i(pend), .base_i(base_q), .found_o(pend_any),
    .pos_o(pend_pos), .idx_o(out_idx)
  );

  irq_prio_pick #(.N(N)) u_pick_svc (
    .vec_i(isr_eff), .base_i(base_q), .found_o(isr_any),
    .pos_o(isr_pos), .idx_o(isr_idx)
  );

  assign out_req = pend_any && (!isr_any || (pend_pos < isr_pos));

  // isr_idx is the in-service winner, kept for the checker
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned N    = 8,
  parameter int unsigned CASC = 2,
  localparam int unsigned IW  = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req_lines,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  trig_level,
  input logic          is_master,
  input logic          nested_mode,
  input logic          auto_eoi,
  input logic          rotate_aeoi,
  input logic [N-1:0]  isr_clr,
  input logic          ack,
  input logic          out_req,
  input logic [IW-1:0] out_idx,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  prev_q,
  input logic [N-1:0]  isr_q,
  input logic [IW-1:0] base_q,
  input logic [IW-1:0] isr_idx
);
  logic [N-1:0] blk;
  assign blk = (is_master && nested_mode) ? (isr_q & ~(N'(1) << CASC)) : isr_q;

  p_level_follow_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & $past(trig_level)) == ($past(req_lines) & $past(trig_level))));

  p_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr_q & ~$past(irr_q) & ~$past(trig_level)
               & ~($past(req_lines) & ~$past(prev_q))) == '0));

  p_pending_needed_r4: assert property (@(posedge clk) disable iff (rst)
    out_req |-> (irr_q[out_idx] && !mask[out_idx]));

  p_not_in_service_r5: assert property (@(posedge clk) disable iff (rst)
    out_req |-> !blk[out_idx]);

  p_svc_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (blk != '0 && (isr_idx == out_idx)) |-> !out_req);

  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && out_req && !auto_eoi) |=> isr_q[$past(out_idx)]);

  p_rotate_base_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && out_req && auto_eoi && rotate_aeoi) |=> (base_q == IW'($past(out_idx) + 1'b1)));

  p_ack_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && !out_req && isr_clr == '0) |=> (isr_q == $past(isr_q) && base_q == $past(base_q)));
endmodule

bind irq_resolver irq_resolver_chk #(.N(N), .CASC(CASC)) u_chk (
  .clk(clk), .rst(rst), .req_lines(req_lines), .mask(mask),
  .trig_level(trig_level), .is_master(is_master), .nested_mode(nested_mode),
  .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi), .isr_clr(isr_clr),
  .ack(ack), .out_req(out_req), .out_idx(out_idx), .irr_q(irr_q),
  .prev_q(prev_q), .isr_q(isr_q), .base_q(base_q), .isr_idx(isr_idx)
);

// File: tb/tb_irq_resolver.sv
`timescale 1ns/100ps
module tb_irq_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_lines = '0, mask = '0, trig_level = '0, isr_clr = '0;
  logic       is_master = 1'b1, nested_mode = 1'b0, auto_eoi = 1'b0, rotate_aeoi = 1'b0;
  logic       ack = 1'b0;
  logic       out_req;
  logic [2:0] out_idx;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  typedef struct {
    string    tag;
    bit       req;
    bit [2:0] idx;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_resolver dut (
    .clk(clk), .rst(rst), .req_lines(req_lines), .mask(mask),
    .trig_level(trig_level), .is_master(is_master), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi), .isr_clr(isr_clr),
    .ack(ack), .out_req(out_req), .out_idx(out_idx)
  );

  // monitor: pop each expected item and compare with the outputs
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      n_chk++;
      if (out_req !== e.req || (e.req && out_idx !== e.idx)) begin
        n_err++;
        $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d",
                 e.tag, out_req, out_idx, e.req, e.idx);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input bit r, input bit [2:0] i);
    exp_t e;
    #0.2;
    e.tag = tag; e.req = r; e.idx = i;
    sb_q.push_back(e);
    #0.1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic clear_isr(input logic [7:0] v);
    isr_clr = v; step(); isr_clr = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    chk("R12 reset clears state", 0, 0);

    req_lines = 8'h28; step();
    chk("R2 edge latch, R3 base 0 winner", 1, 3);
    mask = 8'h08; chk("R4 masked best", 1, 5);
    mask = 8'h28; chk("R4 all masked", 0, 0);
    mask = 8'h00;
    req_lines = 8'h00; step();
    chk("R2 low line keeps request", 1, 3);

    pulse_ack();
    chk("R5 in-service 3 blocks 5", 0, 0);
    clear_isr(8'h08);
    chk("R9 clear reopens 5", 1, 5);
    pulse_ack();
    chk("R7 edge request cleared at ack", 0, 0);
    clear_isr(8'h20);
    chk("R7 nothing left after clear", 0, 0);

    trig_level = 8'h02; req_lines = 8'h02; step();
    chk("R1 level request", 1, 1);
    pulse_ack();
    chk("R5 equal rank blocks", 0, 0);
    clear_isr(8'h02);
    chk("R7 level request survives ack", 1, 1);
    req_lines = 8'h00; step();
    chk("R1 level request follows low", 0, 0);

    mask = 8'h40; req_lines = 8'h40; step();
    chk("R10 masked pending", 0, 0);
    pulse_ack();
    chk("R10 ack without output", 0, 0);
    mask = 8'h00; chk("R10 request untouched", 1, 6);
    pulse_ack();
    clear_isr(8'h40);
    req_lines = 8'h00; step();
    chk("R10 cleanup", 0, 0);

    req_lines = 8'h04; step();
    chk("R6 setup", 1, 2);
    pulse_ack();
    req_lines = 8'h00; step();
    req_lines = 8'h04; step();
    chk("R5 bit2 blocks without nesting", 0, 0);
    nested_mode = 1'b1; chk("R6 master nested ignores bit2", 1, 2);
    is_master = 1'b0;   chk("R6 slave keeps bit2", 0, 0);
    is_master = 1'b1;
    pulse_ack();
    clear_isr(8'hFF);
    nested_mode = 1'b0; req_lines = 8'h00; step();
    chk("R6 cleanup", 0, 0);

    auto_eoi = 1'b1; rotate_aeoi = 1'b1;
    req_lines = 8'h11; step();
    chk("R8 setup", 1, 0);
    pulse_ack();
    chk("R8 no in-service, base 1", 1, 4);
    req_lines = 8'h10; step();
    req_lines = 8'h11; step();
    chk("R3 index 0 lowest at base 1", 1, 4);
    pulse_ack();
    chk("R8 base 5 after 4", 1, 0);
    req_lines = 8'h51; step();
    chk("R3 index 6 ahead of 0 at base 5", 1, 6);
    rotate_aeoi = 1'b0;
    pulse_ack();
    chk("R8 no rotate keeps base", 1, 0);
    req_lines = 8'h71; step();
    chk("R8 base still 5", 1, 5);
    pulse_ack();
    pulse_ack();
    chk("R8 cleanup", 0, 0);
    auto_eoi = 1'b0; req_lines = 8'h00; step();

    req_lines = 8'h08; step();
    req_lines = 8'h00; step();
    chk("R11 setup", 1, 3);
    ack = 1'b1; req_lines = 8'h08; step(); ack = 1'b0;
    chk("R11 in-service blocks", 0, 0);
    clear_isr(8'h08);
    chk("R11 new edge kept", 1, 3);

    req_lines = 8'h18; step();
    chk("R9 setup", 1, 3);
    ack = 1'b1; isr_clr = 8'h08; step(); ack = 1'b0; isr_clr = '0;
    chk("R9 set wins over clear", 0, 0);

    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule